// File: doc/BRIEF.md
# RTC Alarm and Tick Interrupt Unit

This unit sits beside a real-time clock counter and turns its state into two interrupt causes. It holds an alarm time word and an alarm date word in BCD. It compares them on every cycle with the running time and date words from the counter. The alarm flag is set only when the comparison first becomes true.

A second flag, the tick flag, is set on the rising edge of one of eight sub-second prescaler taps. The tap is chosen by a 3-bit select value, so the tick period runs from one second down to 1/128 second in powers of two.

Each flag has its own enable bit. The interrupt line and the wake-up request are both raised while any flag is set together with its enable. Software clears a flag by writing 1 to its bit. The surrounding register decode reaches this unit through a write strobe, a select code and a data word.

Top module: `rtc_alarm_irq`

## Requirements
- R1: Reset (active-low `rstN`) clears both flags, both enables, the alarm time and date words and the tick select. `irq` and `wakeReq` are low during reset and right after it.
- R2: The alarm flag (`flags[0]`) is set when `curTime` equals the alarm time word and `curDate` equals the alarm date word. A match of the time word alone, or of the date word alone, does not set it.
- R3: The alarm flag sets only on the cycle in which the full match turns from false to true. A match that is still holding after the flag is cleared does not set it again. A match already present when reset is released does not set it.
- R4: The tick flag (`flags[1]`) is set on a rising edge of `prescTaps[k]`, where k is the tick select value. Tap k has a period of 2^-k second, so select values 0 to 7 give 1 s down to 1/128 s. Edges on the taps that are not selected have no effect.
- R5: A write with `wrSel`=1 clears every flag whose bit in `wrData[1:0]` is 1. A 0 bit leaves its flag unchanged.
- R6: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: A write with `wrSel`=0 loads the enables from `wrData[1:0]` (bit 0 for the alarm, bit 1 for the tick). `irq` is high exactly when some flag is set and its enable bit is 1.
- R8: `wakeReq` follows the same condition as `irq` in every cycle.
- R9: `wrSel`=2 loads the alarm time word and `wrSel`=3 loads the alarm date word, both from the low bits of `wrData`. `wrSel`=4 loads the tick select from `wrData[2:0]`. Codes 5 to 7 are ignored and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 3 | Write target code |
| wrData | input | DATE_W (24) | Write data |
| curTime | input | TIME_W (22) | Running BCD time word |
| curDate | input | DATE_W (24) | Running BCD date word |
| prescTaps | input | TAP_N (8) | Prescaler taps; tap k has a period of 2^-k s |
| flags | output | 2 | Tick flag (bit 1) and alarm flag (bit 0) |
| irq | output | 1 | Combined interrupt |
| wakeReq | output | 1 | Wake-up request |

## Verification
Every internal state appears at the ports within one clock edge. A wrong flag shows directly on `flags`. A wrong enable or a missed clear shows on `irq` and `wakeReq` in the cycle after the write. A stale edge detector on the match shows as a second alarm, or a missing one, in the cycle the time or date words change. A mistaken tick select shows as a tick on the first rising edge of the wrong tap. The stimulus includes a match held across a clear, a set and a clear landing together, and edges on taps that are not selected.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  typedef enum logic [2:0] {
    SEL_ENABLE     = 3'd0,
    SEL_FLAG_CLR   = 3'd1,
    SEL_ALARM_TIME = 3'd2,
    SEL_ALARM_DATE = 3'd3,
    SEL_TICK_RATE  = 3'd4
  } wr_sel_e;

  typedef struct packed {
    logic       wrEnable;
    logic       wrAlarmTime;
    logic       wrAlarmDate;
    logic       wrTickSel;
    logic [1:0] clrMask;
    logic       setTick;
    logic       setAlarm;
  } strobes_t;

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int TAP_N  = 8,
  parameter int TSEL_W = $clog2(TAP_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [1:0]        wrLow,
  input  logic              fullMatch,
  input  logic [TSEL_W-1:0] tickSel,
  input  logic [TAP_N-1:0]  prescTaps,
  output strobes_t          stb
);

  logic             matchPrev;
  logic [TAP_N-1:0] tapsPrev;

  // Both edge detectors reset high, so a level present at release is not an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPrev <= 1'b1;
      tapsPrev  <= '1;
    end else begin
      matchPrev <= fullMatch;
      tapsPrev  <= prescTaps;
    end
  end

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_ENABLE:     stb.wrEnable    = 1'b1;
        SEL_FLAG_CLR:   stb.clrMask     = wrLow;
        SEL_ALARM_TIME: stb.wrAlarmTime = 1'b1;
        SEL_ALARM_DATE: stb.wrAlarmDate = 1'b1;
        SEL_TICK_RATE:  stb.wrTickSel   = 1'b1;
        default:        ;
      endcase
    end
    stb.setAlarm = fullMatch & ~matchPrev;
    stb.setTick  = prescTaps[tickSel] & ~tapsPrev[tickSel];
  end

  // R3: a match edge cannot repeat on the next cycle
  assert_alarm_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.setAlarm |=> !stb.setAlarm);

  // R4: with the select held, a tap edge cannot repeat on the next cycle
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setTick && !stb.wrTickSel) |=> !stb.setTick);

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int TIME_W = 22,
  parameter int DATE_W = 24,
  parameter int DATA_W = 24,
  parameter int TSEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TIME_W-1:0] curTime,
  input  logic [DATE_W-1:0] curDate,
  output logic              fullMatch,
  output logic [TSEL_W-1:0] tickSel,
  output logic [1:0]        flags,
  output logic [1:0]        enables
);

  logic [TIME_W-1:0] alarmTime;
  logic [DATE_W-1:0] alarmDate;

  assign fullMatch = (curTime == alarmTime) && (curDate == alarmDate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enables   <= '0;
      alarmTime <= '0;
      alarmDate <= '0;
      tickSel   <= '0;
      flags     <= '0;
    end else begin
      if (stb.wrEnable)    enables   <= wrData[1:0];
      if (stb.wrAlarmTime) alarmTime <= wrData[TIME_W-1:0];
      if (stb.wrAlarmDate) alarmDate <= wrData[DATE_W-1:0];
      if (stb.wrTickSel)   tickSel   <= wrData[TSEL_W-1:0];
      // A set event overrides a clear in the same cycle.
      flags <= (flags & ~stb.clrMask) | {stb.setTick, stb.setAlarm};
    end
  end

  // R2: an alarm event shows in the flag on the next cycle
  assert_alarm_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setAlarm |=> flags[0]);

  // R6: a tick event wins over a clear landing in the same cycle
  assert_tick_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setTick && stb.clrMask[1]) |=> flags[1]);

  // R5: a clear without a set event drops the tick flag
  assert_tick_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask[1] && !stb.setTick) |=> !flags[1]);

  // R3: the alarm flag rises only after an alarm event
  assert_alarm_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(stb.setAlarm));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int TIME_W = 22,
  parameter int DATE_W = 24,
  parameter int TAP_N  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATE_W-1:0] wrData,
  input  logic [TIME_W-1:0] curTime,
  input  logic [DATE_W-1:0] curDate,
  input  logic [TAP_N-1:0]  prescTaps,
  output logic [1:0]        flags,
  output logic              irq,
  output logic              wakeReq
);

  localparam int TSEL_W = $clog2(TAP_N);

  strobes_t          stb;
  logic              fullMatch;
  logic [TSEL_W-1:0] tickSel;
  logic [1:0]        enables;

  rtc_alarm_ctrl #(.TAP_N(TAP_N), .TSEL_W(TSEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrLow     (wrData[1:0]),
    .fullMatch (fullMatch),
    .tickSel   (tickSel),
    .prescTaps (prescTaps),
    .stb       (stb)
  );

  rtc_alarm_dp #(.TIME_W(TIME_W), .DATE_W(DATE_W), .DATA_W(DATE_W), .TSEL_W(TSEL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .curTime   (curTime),
    .curDate   (curDate),
    .fullMatch (fullMatch),
    .tickSel   (tickSel),
    .flags     (flags),
    .enables   (enables)
  );

  assign irq     = |(flags & enables);
  assign wakeReq = |(flags & enables);

  // R8: the wake-up request never differs from the interrupt
  assert_wake_tracks_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq == irq);

  // R7: with no flag set there is no interrupt
  assert_no_irq_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flags == 2'b00) |-> !irq);

endmodule

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [23:0] wrData = '0;
  logic [21:0] curTime = '0;
  logic [23:0] curDate = '0;
  logic [7:0]  prescTaps = '0;
  logic [1:0]  flags;
  logic        irq;
  logic        wakeReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .curTime(curTime), .curDate(curDate), .prescTaps(prescTaps),
    .flags(flags), .irq(irq), .wakeReq(wakeReq)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [23:0] data;
    logic [21:0] tm;
    logic [23:0] dt;
    logic [7:0]  taps;
    logic [1:0]  expFlags;
    logic        expIrq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 24'h000000, 22'h000000, 24'h000000, 8'h00, 2'b00, 1'b0}, // R3 match held at release
    '{1'b1, 3'd2, 24'h123456, 22'h000000, 24'h000000, 8'h00, 2'b00, 1'b0}, // R9 alarm time
    '{1'b1, 3'd3, 24'h250612, 22'h000000, 24'h000000, 8'h00, 2'b00, 1'b0}, // R9 alarm date
    '{1'b1, 3'd0, 24'h000003, 22'h000000, 24'h000000, 8'h00, 2'b00, 1'b0}, // R7 enable both
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250611, 8'h00, 2'b00, 1'b0}, // R2 time only
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h00, 2'b01, 1'b1}, // R2 full match
    '{1'b1, 3'd1, 24'h000001, 22'h123456, 24'h250612, 8'h00, 2'b00, 1'b0}, // R5 clear alarm
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h00, 2'b00, 1'b0}, // R3 no re-set
    '{1'b0, 3'd0, 24'h000000, 22'h123457, 24'h250612, 8'h00, 2'b00, 1'b0}, // R2 date only
    '{1'b1, 3'd1, 24'h000001, 22'h123456, 24'h250612, 8'h00, 2'b01, 1'b1}, // R6 set beats clear
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h01, 2'b11, 1'b1}, // R4 tap 0 edge
    '{1'b1, 3'd1, 24'h000000, 22'h123456, 24'h250612, 8'h01, 2'b11, 1'b1}, // R5 write 0
    '{1'b1, 3'd1, 24'h000002, 22'h123456, 24'h250612, 8'h01, 2'b01, 1'b1}, // R5 clear tick
    '{1'b1, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h01, 2'b01, 1'b0}, // R7 disable
    '{1'b1, 3'd0, 24'h000002, 22'h123456, 24'h250612, 8'h01, 2'b01, 1'b0}, // R7 tick enable only
    '{1'b1, 3'd4, 24'h000003, 22'h123456, 24'h250612, 8'h01, 2'b01, 1'b0}, // R9 select 3
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h08, 2'b11, 1'b1}, // R4 tap 3 edge
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h00, 2'b11, 1'b1}, // R4 falling edge
    '{1'b1, 3'd1, 24'h000003, 22'h123456, 24'h250612, 8'h01, 2'b00, 1'b0}, // R4 other tap ignored
    '{1'b0, 3'd0, 24'h000000, 22'h123456, 24'h250612, 8'h09, 2'b10, 1'b1}, // R4 tap 3 again
    '{1'b1, 3'd5, 24'hFFFFFF, 22'h123456, 24'h250612, 8'h09, 2'b10, 1'b1}, // R9 unused code
    '{1'b1, 3'd4, 24'h000007, 22'h123456, 24'h250612, 8'h09, 2'b10, 1'b1}, // R9 select 7
    '{1'b1, 3'd1, 24'h000002, 22'h123456, 24'h250612, 8'h89, 2'b10, 1'b1}  // R4 R6 tap 7 wins
  };

  task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkOuts(input string req, input logic [1:0] expF, input logic expI);
    check(req, "flags", flags, expF);
    check(req, "irq", {1'b0, irq}, {1'b0, expI});
    check("R8", "wakeReq", {1'b0, wakeReq}, {1'b0, expI});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: state while in reset
    repeat (3) @(posedge clk);
    #1 checkOuts("R1", 2'b00, 1'b0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn      = VECS[i].wr;
      wrSel     = VECS[i].sel;
      wrData    = VECS[i].data;
      curTime   = VECS[i].tm;
      curDate   = VECS[i].dt;
      prescTaps = VECS[i].taps;
      @(posedge clk);
      #1 checkOuts($sformatf("vec%0d", i), VECS[i].expFlags, VECS[i].expIrq);
    end

    // R1: a reset in mid-run clears flags, enables and the tick select
    @(negedge clk);
    wrEn = 1'b0; rstN = 1'b0;
    curTime = '0; curDate = '0; prescTaps = '0;
    #1 checkOuts("R1", 2'b00, 1'b0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #1 checkOuts("R3", 2'b00, 1'b0);   // zero alarm matches zero words, no event
    @(negedge clk) prescTaps = 8'h01;   // tick select back to 0
    @(posedge clk);
    #1 checkOuts("R1", 2'b10, 1'b0);    // enables cleared

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule